// File: doc/BRIEF.md
# PRD Table Builder

This block turns a list of scatter-gather segments into a table of physical region descriptors for a bus-master disk controller. Each segment arrives as a 32-bit bus address and a byte length over a valid/ready handshake, and a flag marks the final segment of a list. The block cuts every segment into pieces that never cross a 64 KiB address boundary. For each piece it writes a two-word entry, an address word followed by a control word, into a descriptor memory, one word per cycle.

The block marks the end of the table in the final control word and counts the entries it produces. When a list needs more entries than the table holds, or when it contains no bytes at all, the block reports a fall-back condition instead of a count. A mode input chooses an alternate control-word encoding for controllers that count in 32-bit units. Software then either starts the bus master on the table or moves the transfer to programmed I/O.

Top module: `prd_table_builder`

## Requirements
- R1: After reset `seg_ready` is 1 and `wr_en` and `done` are 0. A segment is taken on a cycle with `seg_valid` and `seg_ready` both high, and `seg_ready` is low while the block is writing. A segment of length 0 produces no entry.
- R2: Each piece is min(0x10000 minus the low 16 bits of the current address, remaining bytes). The address then advances and the remaining length drops by the piece size, so no entry spans two 64 KiB-aligned regions.
- R3: Entry k is written as two words: word index 2k holds the address and word index 2k+1 holds the control word. Entries are written in order, at most one word per cycle.
- R4: In normal mode (`alt_mode`=0) a piece of exactly 0x10000 bytes becomes two entries of 0x8000 bytes each, at A and at A+0x8000.
- R5: In normal mode a control word carries the byte count in bits 15:0 and zeros in bits 30:16. Bit 31 is set only in the final control word of the list.
- R6: In alternate mode (`alt_mode`=1) a control word holds ((piece>>2)-1) modulo 2^16 in bits 31:16 and zeros in bits 15:0. No end-of-table bit is set, and a 0x10000-byte piece is not halved.
- R7: A list that needs more than CAP entries ends with `fallback`=1 and `done_count`=0. No word index at or above 2*CAP is written, and the rest of the list is still consumed up to its last segment. A list of exactly CAP entries succeeds.
- R8: A list whose segments hold no bytes in total ends with `fallback`=1 and `done_count`=0.
- R9: `done` is a one-cycle pulse. On success it comes with `fallback`=0 and `done_count` equal to the number of entries. The block then accepts the next list.
- R10: The encoding mode is taken from `alt_mode` when the first segment of a list is accepted. It holds for the whole list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Block can take a segment |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Segment closes the list |
| alt_mode | input | 1 | 1 selects the 32-bit-unit control encoding |
| wr_en | output | 1 | Descriptor word write strobe |
| wr_idx | output | $clog2(2*CAP) | Word index in the descriptor memory |
| wr_data | output | 32 | Descriptor word |
| done | output | 1 | One-cycle end-of-list pulse |
| done_count | output | $clog2(CAP+1) | Entries produced, 0 on failure |
| fallback | output | 1 | Table could not be built; use programmed I/O |

## Verification
The bench builds the block with CAP=6, so a table fills after three full 64 KiB regions in normal mode. This small capacity brings both the exactly-full list and the one-entry-too-many list within reach of short stimulus. With the default LEN_W=32, segments longer than 64 KiB exercise the splitting across several boundaries, including aligned full regions that the normal mode halves.

// File: rtl/prd_pkg.sv
package prd_pkg;
    localparam logic [16:0] REGION_BYTES = 17'h10000;
    localparam logic [16:0] HALF_REGION  = 17'h08000;
    localparam logic [31:0] EOT_BIT      = 32'h8000_0000;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SPLIT  = 2'd1,
        ST_FINISH = 2'd2
    } build_state_e;
endpackage

// File: rtl/prd_piece_calc.sv
module prd_piece_calc #(
    parameter int LEN_W = 32
) (
    input  logic [31:0]      cur_addr,
    input  logic [LEN_W-1:0] remain,
    input  logic             alt,
    output logic [16:0]      piece
);
    import prd_pkg::*;

    logic [16:0]      room;
    logic [LEN_W-1:0] room_w;
    logic [16:0]      raw;

    always_comb begin
        room   = REGION_BYTES - {1'b0, cur_addr[15:0]};
        room_w = LEN_W'(room);
        raw    = (remain < room_w) ? remain[16:0] : room;
        // normal mode cannot encode a full region in 16 bits: take half now,
        // the other half follows on the next step from addr+0x8000
        piece  = (!alt && raw == REGION_BYTES) ? HALF_REGION : raw;
    end
endmodule

// File: rtl/prd_ctrl_enc.sv
module prd_ctrl_enc (
    input  logic [16:0] piece,
    input  logic        alt,
    output logic [31:0] ctrl
);
    logic [16:0] units;

    always_comb begin
        units = (piece >> 2) - 17'd1;
        if (alt) ctrl = {units[15:0], 16'h0000};
        else     ctrl = {16'h0000, piece[15:0]};
    end
endmodule

// File: rtl/prd_table_builder.sv
module prd_table_builder #(
    parameter int CAP   = 256,
    parameter int LEN_W = 32,
    localparam int CNT_W  = $clog2(CAP + 1),
    localparam int WIDX_W = $clog2(2 * CAP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [31:0]       seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              seg_last,
    input  logic              alt_mode,
    output logic              wr_en,
    output logic [WIDX_W-1:0] wr_idx,
    output logic [31:0]       wr_data,
    output logic              done,
    output logic [CNT_W-1:0]  done_count,
    output logic              fallback
);
    import prd_pkg::*;

    typedef struct packed {
        build_state_e     state;
        logic [31:0]      cur_addr;
        logic [LEN_W-1:0] remain;
        logic             last;
        logic             alt;
        logic             in_list;
        logic             err;
        logic             pend_v;
        logic [31:0]      pend_ctrl;
        logic [CNT_W-1:0] cnt;
    } build_t;

    build_t      q, d;
    logic [16:0] piece;
    logic [31:0] ctrl;
    logic        table_full;

    prd_piece_calc #(.LEN_W(LEN_W)) i_piece (
        .cur_addr (q.cur_addr),
        .remain   (q.remain),
        .alt      (q.alt),
        .piece    (piece)
    );

    prd_ctrl_enc i_enc (
        .piece (piece),
        .alt   (q.alt),
        .ctrl  (ctrl)
    );

    assign table_full = (q.cnt == CNT_W'(CAP));

    always_comb begin
        d          = q;
        seg_ready  = 1'b0;
        wr_en      = 1'b0;
        wr_idx     = '0;
        wr_data    = '0;
        done       = 1'b0;
        done_count = '0;
        fallback   = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                seg_ready = 1'b1;
                if (seg_valid) begin
                    d.cur_addr = seg_addr;
                    d.remain   = q.err ? '0 : seg_len;
                    d.last     = seg_last;
                    if (!q.in_list) d.alt = alt_mode;
                    d.in_list  = 1'b1;
                    d.state    = ST_SPLIT;
                end
            end
            ST_SPLIT: begin
                if (q.remain == '0) begin
                    d.state = q.last ? ST_FINISH : ST_IDLE;
                end else if (q.pend_v) begin
                    // a further entry is coming, so the held word is not the last
                    wr_en    = 1'b1;
                    wr_idx   = WIDX_W'({q.cnt - CNT_W'(1), 1'b1});
                    wr_data  = q.pend_ctrl;
                    d.pend_v = 1'b0;
                end else if (table_full) begin
                    d.err    = 1'b1;
                    d.remain = '0;
                end else begin
                    wr_en       = 1'b1;
                    wr_idx      = WIDX_W'({q.cnt, 1'b0});
                    wr_data     = q.cur_addr;
                    d.pend_ctrl = ctrl;
                    d.pend_v    = 1'b1;
                    d.cnt       = q.cnt + CNT_W'(1);
                    d.cur_addr  = q.cur_addr + 32'(piece);
                    d.remain    = q.remain - LEN_W'(piece);
                end
            end
            ST_FINISH: begin
                done = 1'b1;
                if (!q.err && q.cnt != '0) begin
                    wr_en      = 1'b1;
                    wr_idx     = WIDX_W'({q.cnt - CNT_W'(1), 1'b1});
                    wr_data    = q.pend_ctrl | (q.alt ? 32'h0 : EOT_BIT);
                    done_count = q.cnt;
                end else begin
                    fallback = 1'b1;
                end
                d.state   = ST_IDLE;
                d.cnt     = '0;
                d.err     = 1'b0;
                d.pend_v  = 1'b0;
                d.in_list = 1'b0;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state     <= ST_IDLE;
            q.cur_addr  <= '0;
            q.remain    <= '0;
            q.last      <= 1'b0;
            q.alt       <= 1'b0;
            q.in_list   <= 1'b0;
            q.err       <= 1'b0;
            q.pend_v    <= 1'b0;
            q.pend_ctrl <= '0;
            q.cnt       <= '0;
        end else begin
            q <= d;
        end
    end

    AST_READY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_ready |-> !wr_en); // R1
    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SPLIT && q.remain != '0 && !q.pend_v && !table_full)
        |-> (18'(q.cur_addr[15:0]) + 18'(piece) <= 18'h10000)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_idx) < 32'(2 * CAP))); // R7
    AST_FAIL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fallback) |-> (done_count == '0 && !wr_en)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && seg_ready)); // R9
endmodule

// File: tb/test_prd_table_builder.sv
module test_prd_table_builder;
    localparam int CAP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_valid = 1'b0;
    logic        seg_ready;
    logic [31:0] seg_addr = '0;
    logic [31:0] seg_len = '0;
    logic        seg_last = 1'b0;
    logic        alt_mode = 1'b0;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic        done;
    logic [2:0]  done_count;
    logic        fallback;

    always #2 clk = ~clk;

    prd_table_builder #(.CAP(CAP), .LEN_W(32)) i_prd_table_builder (
        .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
        .alt_mode(alt_mode), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(done), .done_count(done_count), .fallback(fallback)
    );

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    longint    sa[$];
    longint    sl[$];
    bit        sm[$];
    int        exp_idx[$];
    bit [31:0] exp_dat[$];
    int        exp_cnt;
    bit        exp_fb;
    bit        got_done;
    int        cycles = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // reference: per-segment walk, split, capacity, end marker
    task automatic model();
        longint a, r, p, room;
        int cnt = 0;
        bit err = 0, pv = 0;
        bit [31:0] pc = 0;
        bit m = sm[0];
        exp_idx.delete(); exp_dat.delete();
        foreach (sa[i]) begin
            a = sa[i]; r = sl[i];
            while (r > 0 && !err) begin
                room = 65536 - (a & 65535);
                p = (r < room) ? r : room;
                if (!m && p == 65536) p = 32768;
                if (pv) begin exp_idx.push_back(2*cnt-1); exp_dat.push_back(pc); pv = 0; end
                if (cnt == CAP) begin err = 1; break; end
                exp_idx.push_back(2*cnt); exp_dat.push_back(a[31:0]);
                pc = m ? ((((p >> 2) - 1) & 64'hFFFF) << 16) : (p & 64'hFFFF);
                pv = 1; cnt++;
                a = (a + p) & 64'hFFFF_FFFF; r = r - p;
            end
        end
        if (!err && cnt > 0) begin
            exp_idx.push_back(2*cnt-1);
            exp_dat.push_back(pc | (m ? 32'h0 : 32'h8000_0000));
            exp_cnt = cnt; exp_fb = 0;
        end else begin
            exp_cnt = 0; exp_fb = 1;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (exp_idx.size() == 0) begin
                    check(0, cur_tag, "unexpected write idx", wr_idx, 0);
                end else begin
                    check(wr_idx == exp_idx[0][3:0], "R3", "word index", wr_idx, exp_idx[0]);
                    check(wr_data == exp_dat[0], cur_tag, "word data", wr_data, exp_dat[0]);
                    void'(exp_idx.pop_front()); void'(exp_dat.pop_front());
                end
            end
            if (done) begin
                got_done = 1;
                check(fallback == exp_fb, cur_tag, "fallback", fallback, exp_fb);
                check(done_count == exp_cnt[2:0], cur_tag, "done_count", done_count, exp_cnt);
            end
        end
    end

    task automatic send(longint a, longint l, bit last, bit m);
        @(negedge clk);
        seg_valid = 1; seg_addr = a[31:0]; seg_len = l[31:0]; seg_last = last; alt_mode = m;
        while (!seg_ready) @(negedge clk);
        @(posedge clk);
        #1 seg_valid = 0;
    endtask

    task automatic run(string tag);
        int w = 0;
        cur_tag = tag;
        model();
        got_done = 0;
        foreach (sa[i]) send(sa[i], sl[i], i == sa.size() - 1, sm[i]);
        while (!got_done && w < 2000) begin @(negedge clk); w++; end
        check(got_done, tag, "done seen", got_done, 1);
        check(exp_idx.size() == 0, tag, "words left unwritten", exp_idx.size(), 0);
        @(negedge clk);
        check(seg_ready && !done, "R9", "idle after done", {seg_ready, done}, 2);
        sa.delete(); sl.delete(); sm.delete();
    endtask

    task automatic seg(longint a, longint l, bit m);
        sa.push_back(a); sl.push_back(l); sm.push_back(m);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; failures++;
                $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        longint lcg = 64'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(seg_ready && !wr_en && !done, "R1", "reset outputs", {seg_ready, wr_en, done}, 4);
        // R5: single small entry carries end-of-table bit
        seg(32'h1000_0100, 32'h200, 0); run("R5");
        // R2: crossing a 64 KiB boundary
        seg(32'h0001_FF00, 32'h300, 0); run("R2");
        // R4: aligned full region halved
        seg(32'h0002_0000, 32'h10000, 0); run("R4");
        // R1: zero-length segment in the middle of a list
        seg(32'h0000_4000, 32'h40, 0); seg(32'h0000_8000, 0, 0); seg(32'h0005_0010, 32'h20, 0); run("R1");
        // R6: alternate encoding, full region kept whole
        seg(32'h0003_0000, 32'h10010, 1); run("R6");
        // R7: exactly CAP entries succeeds
        seg(32'h0004_0000, 32'h30000, 0); run("R7");
        // R7: overflow, trailing segments consumed
        seg(32'h0006_0000, 32'h20000, 0); seg(32'h0009_0000, 32'h20000, 0); seg(32'h0100_0000, 32'h10, 0); run("R7");
        // R9: next list after an overflow works
        seg(32'h0200_0002, 32'h100, 0); run("R9");
        // R8: empty list
        seg(32'h0000_1000, 0, 0); run("R8");
        // R10: mode input changes mid-list, first segment decides
        seg(32'h0007_0000, 32'h100, 1); seg(32'h0008_0000, 32'h200, 0); run("R10");
        seg(32'h0007_0000, 32'h100, 0); seg(32'h0008_0000, 32'h200, 1); run("R10");
        // R2: pseudo-random lists
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 1 + k % 3; j++) begin
                lcg = (lcg * 1103515245 + 12345) & 64'hFFFF_FFFF;
                sa.push_back(lcg & 64'hFFFF_FFFE);
                lcg = (lcg * 1103515245 + 12345) & 64'hFFFF_FFFF;
                sl.push_back(lcg % 64'h18000);
                sm.push_back(k[0]);
            end
            run("R2");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule